// File: doc/BRIEF.md
# Run-Ahead Vector Load Data Store

This block decouples a scalar address-generation pipeline from one vector lane. The scalar side computes every address the lane will use. Load addresses and store addresses travel to the lane through two separate first-in first-out queues.

When the scalar side accepts a load address, the block reserves a slot in a small tagged data store. In the same cycle it issues a read request to memory. Memory answers later, in any order, with the address and the data. The block writes that data into the oldest reserved slot whose tag equals the address.

When the lane executes a vector load, the block takes the next queued load address and searches the data store for a filled slot with that tag. A hit hands the data to the lane, retires the queue entry and frees the slot. A miss holds the lane stalled until the data lands. When the lane executes a vector store, the block hands it the next queued store address.

A slow memory answer therefore stalls only the lane. The scalar side keeps running until it runs out of free slots.

Top module: `runahead_load_store`

## Requirements
- R1: After reset both queues are empty and every slot is free. `ld_req_ready` and `st_push_ready` are 1, and `mem_req_valid`, `vld_done` and `lane_stall` are 0 while the lane requests nothing.
- R2: In a cycle where `ld_req_valid` and `ld_req_ready` are both 1, `mem_req_valid` is 1 and `mem_req_addr` equals `ld_req_addr` in that same cycle.
- R3: `ld_req_ready` is 0 while all ENTRIES slots are reserved (default 4). A load offered in that state is not accepted.
- R4: A vector load completes (`vld_done` = 1) only after memory has answered for the queued address. `vld_data` then equals that answer's data, in the same cycle as `vld_done`.
- R5: While `vld_valid` is 1 and the data is absent, `lane_stall` is 1 and `vld_done` is 0. The lookup is retried every cycle.
- R6: Memory answers may arrive out of order with latencies of 1 to 16 cycles. Vector loads still complete in the order their addresses were accepted.
- R7: The same address may be requested twice while the first request is still outstanding. Each request then takes its own slot. Answers fill same-address slots oldest first, and a lookup takes the oldest filled matching slot. So the first load receives the first answer to arrive.
- R8: A slot stays reserved after its data arrives and is freed only when the lane reads it. `ld_req_ready` returns to 1 in the cycle after such a read.
- R9: When `vst_valid` is 1 and the store queue holds an address, `vst_done` is 1 and `vst_addr` shows the oldest store address, in push order. With the store queue empty, `vst_done` is 0 and `lane_stall` is 1.
- R10: `st_push_ready` is 0 while the store queue holds SQ_DEPTH addresses (default 4). A push offered then is dropped and never appears at `vst_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_req_valid | input | 1 | Scalar side offers a vector load address |
| ld_req_addr | input | ADDR_W | Load address |
| ld_req_ready | output | 1 | A slot is free and the load queue has room |
| st_push_valid | input | 1 | Scalar side offers a vector store address |
| st_push_addr | input | ADDR_W | Store address |
| st_push_ready | output | 1 | Store queue has room |
| mem_req_valid | output | 1 | Read request to memory |
| mem_req_addr | output | ADDR_W | Read address |
| mem_rsp_valid | input | 1 | Memory answer present |
| mem_rsp_addr | input | ADDR_W | Address the answer belongs to |
| mem_rsp_data | input | DATA_W | Answer data |
| vld_valid | input | 1 | Lane executes a vector load |
| vld_done | output | 1 | Vector load served this cycle |
| vld_data | output | DATA_W | Load data, valid with vld_done |
| vst_valid | input | 1 | Lane executes a vector store |
| vst_done | output | 1 | Store address delivered this cycle |
| vst_addr | output | ADDR_W | Store address, valid with vst_done |
| lane_stall | output | 1 | A lane operation could not complete this cycle |

## Verification
The read request appears in the same cycle the load address is accepted. A memory answer registered at a clock edge can first satisfy a lookup in the cycle after that edge. `vld_done`, `vld_data`, `vst_done`, `vst_addr` and `lane_stall` respond combinationally, within the cycle in which the lane raises its request. `ld_req_ready` recovers one edge after a slot is read. The bench changes inputs on the falling edge and samples outputs a few time units later in the same low phase. Each result is therefore compared in exactly the cycle it is due. The scoreboard derives the expected load data from the order in which the memory model delivered its answers for each address, so it tracks out-of-order and duplicate-address traffic without knowing slot numbers.

// File: rtl/ralq_pkg.sv
// Package: shared defaults for the run-ahead load/store block.
// Assumes: consumers override these through module parameters when needed.
package ralq_pkg;
    localparam int unsigned DEF_ADDR_W   = 16;
    localparam int unsigned DEF_DATA_W   = 32;
    localparam int unsigned DEF_ENTRIES  = 4;
    localparam int unsigned DEF_SQ_DEPTH = 4;
endpackage

// File: rtl/ralq_addr_fifo.sv
// Module: ralq_addr_fifo
// A register-based FIFO that carries addresses from the scalar side to the lane.
// The head entry is visible combinationally.
// Assumes: the caller never pushes when full or pops when empty.
module ralq_addr_fifo #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;

    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign empty = (cnt_q == '0);
    assign head  = mem_q[rd_q];

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (pop)  rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) mem_q[wr_q] <= push_data;
    end

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full) else $error("fifo push while full");
    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty) else $error("fifo pop while empty");
endmodule

// File: rtl/ralq_tag_store.sv
// Module: ralq_tag_store
// Small tagged data store. Each slot holds a busy bit, a filled bit, an address
// tag, a data word and an age (the number of younger busy slots).
// Reservation takes the lowest free slot. A memory answer fills the oldest busy,
// unfilled slot with a matching tag. A lookup returns the oldest filled slot with
// a matching tag and frees it when look_en is set.
// Assumes: rsv_en only while free_avail; every answer matches a pending slot.
module ralq_tag_store #(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsv_en,
    input  logic [ADDR_W-1:0] rsv_tag,
    output logic              free_avail,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              look_en,
    input  logic [ADDR_W-1:0] look_tag,
    output logic              look_hit,
    output logic [DATA_W-1:0] look_data
);
    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int unsigned AGE_W = $clog2(ENTRIES) + 1;

    logic [ENTRIES-1:0] busy_q, filled_q;
    logic [ADDR_W-1:0]  tag_q  [ENTRIES];
    logic [DATA_W-1:0]  data_q [ENTRIES];
    logic [AGE_W-1:0]   age_q  [ENTRIES];

    logic [IDX_W-1:0] free_idx, fill_idx, look_idx;
    logic             fill_hit;
    logic [AGE_W-1:0] fill_best, look_best;
    logic             release_en;

    // Pick the lowest-numbered free slot for the next reservation.
    always_comb begin
        free_avail = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!busy_q[i]) begin
                free_avail = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    // Oldest pending slot whose tag matches the memory answer.
    always_comb begin
        fill_hit  = 1'b0;
        fill_idx  = '0;
        fill_best = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (busy_q[i] && !filled_q[i] && tag_q[i] == fill_tag &&
                (!fill_hit || age_q[i] > fill_best)) begin
                fill_hit  = 1'b1;
                fill_idx  = IDX_W'(i);
                fill_best = age_q[i];
            end
        end
    end

    // Oldest filled slot whose tag matches the lane lookup.
    always_comb begin
        look_hit  = 1'b0;
        look_idx  = '0;
        look_best = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (busy_q[i] && filled_q[i] && tag_q[i] == look_tag &&
                (!look_hit || age_q[i] > look_best)) begin
                look_hit  = 1'b1;
                look_idx  = IDX_W'(i);
                look_best = age_q[i];
            end
        end
        look_data = data_q[look_idx];
    end

    assign release_en = look_en && look_hit;

    // Slot state: reserve, fill, release, and age maintenance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= '0;
            filled_q <= '0;
            for (int i = 0; i < ENTRIES; i++) age_q[i] <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (busy_q[i]) begin
                    age_q[i] <= age_q[i] + AGE_W'(rsv_en)
                              - AGE_W'(release_en && age_q[i] > look_best);
                end
            end
            if (fill_en && fill_hit) filled_q[fill_idx] <= 1'b1;
            if (release_en) begin
                busy_q[look_idx]   <= 1'b0;
                filled_q[look_idx] <= 1'b0;
            end
            if (rsv_en) begin
                busy_q[free_idx]   <= 1'b1;
                filled_q[free_idx] <= 1'b0;
                age_q[free_idx]    <= '0;
            end
        end
    end

    // Tag and data payload; no reset needed.
    always_ff @(posedge clk) begin
        if (rsv_en) tag_q[free_idx] <= rsv_tag;
        if (fill_en && fill_hit) data_q[fill_idx] <= fill_data;
    end

    assert_reserve_needs_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_en |-> free_avail) else $error("reservation without free slot");
    assert_read_frees_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (release_en && !rsv_en) |=> ($countones(busy_q) == $past($countones(busy_q)) - 1))
        else $error("slot not released after read");
endmodule

// File: rtl/runahead_load_store.sv
// Module: runahead_load_store (top)
// Connects the scalar side to one vector lane. Accepted load addresses reserve a
// slot, issue a memory read and enter the load queue. Store addresses enter the
// store queue. Lane loads look up the queued address in the tag store; lane
// stores take the queued store address. Lane handshakes are combinational.
// Assumes: the memory answer stream carries the requested address back.
module runahead_load_store #(
    parameter int unsigned ADDR_W   = ralq_pkg::DEF_ADDR_W,
    parameter int unsigned DATA_W   = ralq_pkg::DEF_DATA_W,
    parameter int unsigned ENTRIES  = ralq_pkg::DEF_ENTRIES,
    parameter int unsigned SQ_DEPTH = ralq_pkg::DEF_SQ_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_req_valid,
    input  logic [ADDR_W-1:0] ld_req_addr,
    output logic              ld_req_ready,
    input  logic              st_push_valid,
    input  logic [ADDR_W-1:0] st_push_addr,
    output logic              st_push_ready,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_addr,
    input  logic [DATA_W-1:0] mem_rsp_data,
    input  logic              vld_valid,
    output logic              vld_done,
    output logic [DATA_W-1:0] vld_data,
    input  logic              vst_valid,
    output logic              vst_done,
    output logic [ADDR_W-1:0] vst_addr,
    output logic              lane_stall
);
    localparam int unsigned LQ_DEPTH = ENTRIES;

    logic              ld_fire, free_avail, look_hit;
    logic              lq_full, lq_empty, sq_full, sq_empty;
    logic [ADDR_W-1:0] lq_head;
    logic              look_en, st_fire;

    // Scalar-side acceptance and the matching memory read.
    assign ld_req_ready  = free_avail && !lq_full;
    assign ld_fire       = ld_req_valid && ld_req_ready;
    assign mem_req_valid = ld_fire;
    assign mem_req_addr  = ld_req_addr;
    assign st_push_ready = !sq_full;
    assign st_fire       = st_push_valid && st_push_ready;

    // Lane side: load lookup and store address delivery.
    assign look_en    = vld_valid && !lq_empty;
    assign vld_done   = look_en && look_hit;
    assign vst_done   = vst_valid && !sq_empty;
    assign lane_stall = (vld_valid && !vld_done) || (vst_valid && !vst_done);

    ralq_addr_fifo #(.W(ADDR_W), .DEPTH(LQ_DEPTH)) u_load_q (
        .clk(clk), .rst_n(rst_n),
        .push(ld_fire), .push_data(ld_req_addr),
        .pop(vld_done), .head(lq_head),
        .full(lq_full), .empty(lq_empty)
    );

    ralq_addr_fifo #(.W(ADDR_W), .DEPTH(SQ_DEPTH)) u_store_q (
        .clk(clk), .rst_n(rst_n),
        .push(st_fire), .push_data(st_push_addr),
        .pop(vst_done), .head(vst_addr),
        .full(sq_full), .empty(sq_empty)
    );

    ralq_tag_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(ENTRIES)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .rsv_en(ld_fire), .rsv_tag(ld_req_addr), .free_avail(free_avail),
        .fill_en(mem_rsp_valid), .fill_tag(mem_rsp_addr), .fill_data(mem_rsp_data),
        .look_en(look_en), .look_tag(lq_head),
        .look_hit(look_hit), .look_data(vld_data)
    );

    assert_ready_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_done && !mem_req_valid) |=> ld_req_ready)
        else $error("no slot available after a lane read");
endmodule

// File: tb/tb_runahead_load_store.sv
module tb_runahead_load_store;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_req_valid = 1'b0, st_push_valid = 1'b0;
    logic [15:0] ld_req_addr = '0, st_push_addr = '0;
    logic        ld_req_ready, st_push_ready;
    logic        mem_req_valid;
    logic [15:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [15:0] mem_rsp_addr = '0;
    logic [31:0] mem_rsp_data = '0;
    logic        vld_valid = 1'b0, vst_valid = 1'b0;
    logic        vld_done, vst_done, lane_stall;
    logic [31:0] vld_data;
    logic [15:0] vst_addr;

    int    checks = 0, errors = 0;
    int    n_issued = 0, n_served = 0, stall_seen = 0, cyc = 0;
    int    next_lat = 1;
    int    rsp_seq = 0;
    string cur_tag = "R4";

    logic [15:0] pq_a[$];
    int          pq_c[$];
    logic [15:0] dq_a[$];
    logic [31:0] dq_d[$];
    logic [15:0] exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    runahead_load_store dut (
        .clk(clk), .rst_n(rst_n),
        .ld_req_valid(ld_req_valid), .ld_req_addr(ld_req_addr), .ld_req_ready(ld_req_ready),
        .st_push_valid(st_push_valid), .st_push_addr(st_push_addr), .st_push_ready(st_push_ready),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_addr(mem_rsp_addr), .mem_rsp_data(mem_rsp_data),
        .vld_valid(vld_valid), .vld_done(vld_done), .vld_data(vld_data),
        .vst_valid(vst_valid), .vst_done(vst_done), .vst_addr(vst_addr),
        .lane_stall(lane_stall)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WATCHDOG);
            summary();
        end
    end

    // Memory stub: count down pending reads and deliver one answer per cycle.
    always @(negedge clk) begin
        int pick;
        pick = -1;
        for (int i = 0; i < pq_c.size(); i++) if (pq_c[i] > 0) pq_c[i]--;
        for (int i = 0; i < pq_c.size(); i++) if (pick < 0 && pq_c[i] == 0) pick = i;
        if (pick >= 0) begin
            rsp_seq++;
            mem_rsp_valid = 1'b1;
            mem_rsp_addr  = pq_a[pick];
            mem_rsp_data  = {pq_a[pick] ^ 16'hC35A, pq_a[pick]} + 32'(rsp_seq);
            dq_a.push_back(mem_rsp_addr);
            dq_d.push_back(mem_rsp_data);
            pq_a.delete(pick);
            pq_c.delete(pick);
        end else begin
            mem_rsp_valid = 1'b0;
        end
    end

    // Request capture: read issue must mirror the accepted load (R2).
    always @(negedge clk) begin
        #1;
        if (rst_n && mem_req_valid) begin
            chk("R2", "read request valid with accepted load", 64'(ld_req_valid && ld_req_ready), 64'd1);
            chk("R2", "read address", 64'(mem_req_addr), 64'(ld_req_addr));
            pq_a.push_back(mem_req_addr);
            pq_c.push_back(next_lat);
            exp_q.push_back(mem_req_addr);
            n_issued++;
        end
    end

    // Scoreboard monitor: expected data is the earliest undelivered answer for the address.
    always @(negedge clk) begin
        #2;
        if (rst_n && vld_valid && !vst_valid) begin
            chk("R5", "stall while load unserved", 64'(lane_stall), 64'(!vld_done));
            if (lane_stall) stall_seen++;
        end
        if (rst_n && vld_done) begin
            logic [15:0] a;
            int          k;
            n_served++;
            if (exp_q.size() == 0) begin
                chk(cur_tag, "load served with nothing queued", 64'd1, 64'd0);
            end else begin
                a = exp_q.pop_front();
                k = -1;
                for (int i = 0; i < dq_a.size(); i++) if (k < 0 && dq_a[i] == a) k = i;
                if (k < 0) begin
                    chk(cur_tag, "load served before data arrived (R4)", 64'(a), 64'hFFFF_FFFF);
                end else begin
                    chk(cur_tag, "load data (R4)", 64'(vld_data), 64'(dq_d[k]));
                    dq_a.delete(k);
                    dq_d.delete(k);
                end
            end
        end
    end

    task automatic issue_load(logic [15:0] a, int lat);
        @(negedge clk);
        ld_req_valid = 1'b1;
        ld_req_addr  = a;
        next_lat     = lat;
        #3;
        while (!ld_req_ready) begin
            @(negedge clk);
            #3;
        end
        @(negedge clk);
        ld_req_valid = 1'b0;
    endtask

    task automatic lane_drain();
        @(negedge clk);
        vld_valid = 1'b1;
        wait (n_served == n_issued);
        @(negedge clk);
        vld_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #3;
        // R1: reset state
        chk("R1", "ld_req_ready", 64'(ld_req_ready), 64'd1);
        chk("R1", "st_push_ready", 64'(st_push_ready), 64'd1);
        chk("R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);
        chk("R1", "lane_stall", 64'(lane_stall), 64'd0);
        chk("R1", "vld_done", 64'(vld_done), 64'd0);

        // R5: a load waiting on slow memory stalls the lane
        cur_tag = "R5";
        issue_load(16'h0100, 8);
        lane_drain();
        chk("R5", "stall cycles observed", 64'(stall_seen > 0), 64'd1);

        // R3 and R8: fill every slot, data arrives, slots stay reserved until read
        cur_tag = "R8";
        for (int i = 0; i < 4; i++) issue_load(16'h0200 + 16'(i), 16);
        @(negedge clk);
        #3;
        chk("R3", "ready with all slots reserved", 64'(ld_req_ready), 64'd0);
        repeat (24) @(negedge clk);
        #3;
        chk("R8", "ready after data arrived but unread", 64'(ld_req_ready), 64'd0);
        @(negedge clk);
        vld_valid = 1'b1;
        #3;
        chk("R8", "first load served", 64'(vld_done), 64'd1);
        @(negedge clk);
        vld_valid = 1'b0;
        #3;
        chk("R8", "ready after one read", 64'(ld_req_ready), 64'd1);
        lane_drain();

        // R7: same address twice, second answer arrives first
        cur_tag = "R7";
        issue_load(16'h0300, 12);
        issue_load(16'h0300, 2);
        repeat (16) @(negedge clk);
        lane_drain();

        // R6: mixed latencies, overlapping issue and consumption
        cur_tag = "R6";
        fork
            begin
                for (int i = 0; i < 24; i++)
                    issue_load(16'h0400 + 16'((i * 5) % 7), ((i * 11) % 16) + 1);
            end
            begin
                @(negedge clk);
                vld_valid = 1'b1;
                wait (n_issued == 25 + 6 && n_served == n_issued);
                @(negedge clk);
                vld_valid = 1'b0;
            end
        join
        chk("R6", "all loads served", 64'(n_served), 64'(n_issued));

        // R10: store queue fills and drops an extra push
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            st_push_valid = 1'b1;
            st_push_addr  = 16'h0A00 + 16'(i);
            #3;
            chk("R10", "store push accepted", 64'(st_push_ready), 64'd1);
        end
        @(negedge clk);
        st_push_addr = 16'hDEAD;
        #3;
        chk("R10", "ready with store queue full", 64'(st_push_ready), 64'd0);
        @(negedge clk);
        st_push_valid = 1'b0;

        // R9: stores pop in order, then stall when empty
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            vst_valid = 1'b1;
            #3;
            chk("R9", "store done", 64'(vst_done), 64'd1);
            chk("R9", "store address order", 64'(vst_addr), 64'(16'h0A00 + 16'(i)));
        end
        @(negedge clk);
        #3;
        chk("R9", "store done on empty queue", 64'(vst_done), 64'd0);
        chk("R9", "stall on empty store queue", 64'(lane_stall), 64'd1);
        @(negedge clk);
        vst_valid = 1'b0;
        #3;
        chk("R1", "idle lane not stalled", 64'(lane_stall), 64'd0);
        chk("R4", "scoreboard empty", 64'(exp_q.size()), 64'd0);
        summary();
    end
endmodule